// File: doc/BRIEF.md
# Self-Adjusting Increment Stage Pair

This block is a streaming unit that adds a per-stage offset to each data word passing through it. Each stage reads from an input queue and writes to an output queue. Three signals describe each queue: the head word is present, the head word's value, and whether the queue can take a word. A stage holds one register, its current offset, and in any cycle it takes at most one guarded action. If the head word is nonzero and the sink has room, the stage sends the word plus the offset to the sink and consumes the head in the same cycle. If the head word is zero, the stage consumes it silently and raises its own offset by one. Zero words therefore act as in-band control tokens.

The top instantiates two such stages joined by a small channel queue. Each stage has its own starting offset: the first defaults to 1 and the second to 2. A zero that the first stage consumes never enters the channel. A word can still reach the second stage as zero when the first stage's addition wraps, and the second stage then treats it as a control token. The upstream source sees a dequeue strobe, and the downstream consumer sees an enqueue strobe with its data.

Top module: `incChainTop`

## Requirements
- R1: After reset, the first stage's offset is INC_A, the second stage's offset is INC_B and the channel is empty. With no input word present, neither inDeq nor outEnq is raised.
- R2: A stage forwards a word only if the head is present, the head is nonzero and the sink has room. The stage then sends head + offset and consumes the head in that same cycle. inDeq is never high without inValid, and outEnq is never high without outRdy.
- R3: A zero head word is consumed with no output, and it adds one to that stage's offset even when the sink has no room.
- R4: A stage takes at most one action per cycle, and forwarding is tested first. A nonzero head that has no room at its sink stays in place, is not consumed, and leaves the offset unchanged.
- R5: In a cycle where neither guard holds, a stage raises no strobe and keeps its offset.
- R6: Sums wrap modulo 2^W. A first-stage sum that wraps to zero reaches the second stage as a control token.
- R7: Words leave the pair in arrival order, each one raised by both stages' offsets. Zeros consumed by the first stage never reach the output.
- R8: The channel holds at most CHAN_DEPTH words. The first stage forwards only while the channel has a free slot.
- R9: A synchronous active-high reset restores both offsets and empties the channel, even in the middle of traffic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input queue has a head word |
| inData | input | W | Head word of the input queue |
| inDeq | output | 1 | Head word consumed this cycle |
| outRdy | input | 1 | Output queue can take a word |
| outEnq | output | 1 | Word enqueued to the output this cycle |
| outData | output | W | Word being enqueued |

## Verification
The bench targets several corner cases, each with a distinct failure:
- A zero word arriving while the sink is blocked: a design that ties the bump action to output space would stall there forever.
- A nonzero word waiting at a full channel: a wrong guard priority would consume or bump on it.
- A first-stage sum that wraps to exactly zero: a design that ignored the wrap would send a zero word out instead of bumping the second stage.
- A reset in the middle of traffic: if the offsets were not restored, every later output would be shifted.

// File: rtl/incr_pkg.sv
package incr_pkg;

  // Action strobes from a stage's control to its datapath.
  typedef struct packed {
    logic fireAdd;
    logic fireBump;
  } stageStrb_t;

endpackage

// File: rtl/incCtrl.sv
module incCtrl
  import incr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         headValid,
  input  logic [W-1:0] headData,
  input  logic         sinkRdy,
  output stageStrb_t   strb
);

  logic headZero;
  logic addGuard;
  logic bumpGuard;

  assign headZero  = (headData == '0);
  assign addGuard  = headValid && sinkRdy && !headZero;
  assign bumpGuard = headValid && headZero;

  // The forwarding action is tested first; only one action may fire.
  always_comb begin
    strb = '0;
    if (addGuard) begin
      strb.fireAdd = 1'b1;
    end else if (bumpGuard) begin
      strb.fireBump = 1'b1;
    end
  end

endmodule

// File: rtl/incDatapath.sv
module incDatapath
  import incr_pkg::*;
#(
  parameter int W        = 32,
  parameter int INC_INIT = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  stageStrb_t   strb,
  input  logic [W-1:0] headData,
  output logic [W-1:0] sumData,
  output logic [W-1:0] incAmt
);

  localparam logic [W-1:0] INC_RST = W'(INC_INIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      incAmt <= INC_RST;
    end else if (strb.fireBump) begin
      incAmt <= incAmt + W'(1);
    end
  end

  assign sumData = headData + incAmt;

endmodule

// File: rtl/incStage.sv
module incStage
  import incr_pkg::*;
#(
  parameter int W        = 32,
  parameter int INC_INIT = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         headValid,
  input  logic [W-1:0] headData,
  output logic         headDeq,
  input  logic         sinkRdy,
  output logic         sinkEnq,
  output logic [W-1:0] sinkData,
  output stageStrb_t   strb,
  output logic [W-1:0] incAmt
);

  incCtrl #(.W(W)) uCtrl (
    .headValid (headValid),
    .headData  (headData),
    .sinkRdy   (sinkRdy),
    .strb      (strb)
  );

  incDatapath #(.W(W), .INC_INIT(INC_INIT)) uDp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .headData (headData),
    .sumData  (sinkData),
    .incAmt   (incAmt)
  );

  assign headDeq = strb.fireAdd | strb.fireBump;
  assign sinkEnq = strb.fireAdd;

endmodule

// File: rtl/incChannel.sv
module incChannel #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pushEn,
  input  logic [W-1:0]  pushData,
  output logic          full,
  input  logic          popEn,
  output logic          headValid,
  output logic [W-1:0]  headData,
  output logic [CW-1:0] count
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [W-1:0]  slots [DEPTH];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;
  logic          doPush;
  logic          doPop;

  assign full      = (count == CAP);
  assign headValid = (count != '0);
  assign headData  = slots[rdPtr];
  assign doPush    = pushEn && !full;
  assign doPop     = popEn && headValid;

  always_ff @(posedge clk) begin
    if (doPush) begin
      slots[wrPtr] <= pushData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) begin
        wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + AW'(1);
      end
      if (doPop) begin
        rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + AW'(1);
      end
      case ({doPush, doPop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/incChainTop.sv
module incChainTop
  import incr_pkg::*;
#(
  parameter int W          = 32,
  parameter int INC_A      = 1,
  parameter int INC_B      = 2,
  parameter int CHAN_DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic [W-1:0] inData,
  output logic         inDeq,
  input  logic         outRdy,
  output logic         outEnq,
  output logic [W-1:0] outData
);

  localparam int CW = $clog2(CHAN_DEPTH + 1);

  stageStrb_t    strbA;
  stageStrb_t    strbB;
  logic [W-1:0]  incAmtA;
  logic [W-1:0]  incAmtB;
  logic          chanPush;
  logic [W-1:0]  chanIn;
  logic          chanFull;
  logic          chanPop;
  logic          chanValid;
  logic [W-1:0]  chanHead;
  logic [CW-1:0] chanCount;

  incStage #(.W(W), .INC_INIT(INC_A)) uStageA (
    .clk       (clk),
    .rst       (rst),
    .headValid (inValid),
    .headData  (inData),
    .headDeq   (inDeq),
    .sinkRdy   (!chanFull),
    .sinkEnq   (chanPush),
    .sinkData  (chanIn),
    .strb      (strbA),
    .incAmt    (incAmtA)
  );

  incChannel #(.W(W), .DEPTH(CHAN_DEPTH)) uChan (
    .clk       (clk),
    .rst       (rst),
    .pushEn    (chanPush),
    .pushData  (chanIn),
    .full      (chanFull),
    .popEn     (chanPop),
    .headValid (chanValid),
    .headData  (chanHead),
    .count     (chanCount)
  );

  incStage #(.W(W), .INC_INIT(INC_B)) uStageB (
    .clk       (clk),
    .rst       (rst),
    .headValid (chanValid),
    .headData  (chanHead),
    .headDeq   (chanPop),
    .sinkRdy   (outRdy),
    .sinkEnq   (outEnq),
    .sinkData  (outData),
    .strb      (strbB),
    .incAmt    (incAmtB)
  );

endmodule

// File: rtl/incChainChk.sv
module incChainChk
  import incr_pkg::*;
#(
  parameter int W     = 32,
  parameter int INC_A = 1,
  parameter int INC_B = 2,
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          inValid,
  input logic          inDeq,
  input logic          outRdy,
  input logic          outEnq,
  input stageStrb_t    strbA,
  input stageStrb_t    strbB,
  input logic [W-1:0]  incAmtA,
  input logic [W-1:0]  incAmtB,
  input logic [CW-1:0] chanCount
);

  // R2
  deq_needs_head_chk: assert property (@(posedge clk) disable iff (rst)
    inDeq |-> inValid);

  // R2
  enq_needs_room_chk: assert property (@(posedge clk) disable iff (rst)
    outEnq |-> outRdy);

  // R3
  bump_a_chk: assert property (@(posedge clk) disable iff (rst)
    strbA.fireBump |=> (incAmtA == $past(incAmtA) + W'(1)));

  // R3
  bump_b_chk: assert property (@(posedge clk) disable iff (rst)
    strbB.fireBump |=> (incAmtB == $past(incAmtB) + W'(1)));

  // R5
  hold_a_chk: assert property (@(posedge clk) disable iff (rst)
    !strbA.fireBump |=> $stable(incAmtA));

  // R5
  hold_b_chk: assert property (@(posedge clk) disable iff (rst)
    !strbB.fireBump |=> $stable(incAmtB));

  // R8
  room_before_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    strbA.fireAdd |-> (chanCount < CW'(DEPTH)));

  // R8
  chan_bound_chk: assert property (@(posedge clk) disable iff (rst)
    chanCount <= CW'(DEPTH));

  // R9
  reset_restore_chk: assert property (@(posedge clk)
    rst |=> (incAmtA == W'(INC_A)) && (incAmtB == W'(INC_B)) && (chanCount == '0));

endmodule

bind incChainTop incChainChk #(
  .W(W), .INC_A(INC_A), .INC_B(INC_B), .DEPTH(CHAN_DEPTH), .CW(CW)
) uChk (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .inDeq     (inDeq),
  .outRdy    (outRdy),
  .outEnq    (outEnq),
  .strbA     (strbA),
  .strbB     (strbB),
  .incAmtA   (incAmtA),
  .incAmtB   (incAmtB),
  .chanCount (chanCount)
);

// File: tb/sim_incChainTop.sv
`timescale 1ns/1ps
module sim_incChainTop;

  localparam int W     = 32;
  localparam int INC_A = 1;
  localparam int INC_B = 2;
  localparam int DEPTH = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [W-1:0] inData = '0;
  logic         inDeq;
  logic         outRdy = 1'b0;
  logic         outEnq;
  logic [W-1:0] outData;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // Reference model state
  logic [W-1:0] mIncA;
  logic [W-1:0] mIncB;
  logic [W-1:0] mChan[$];
  logic [W-1:0] srcQ[$];
  logic [W-1:0] outLog[$];
  logic [15:0]  lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  incChainTop #(.W(W), .INC_A(INC_A), .INC_B(INC_B), .CHAN_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inDeq(inDeq),
    .outRdy(outRdy), .outEnq(outEnq), .outData(outData)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cycles, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0; inData = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    mIncA = W'(INC_A);
    mIncB = W'(INC_B);
    mChan.delete();
    srcQ.delete();
    outLog.delete();
  endtask

  task automatic step(input bit srcEn, input bit rdy);
    bit aAdd, aBump, bValid, bAdd, bBump;
    logic [W-1:0] bHead, expSum;
    string tagIn, tagOut;
    @(negedge clk);
    inValid = srcEn && (srcQ.size() > 0);
    inData  = inValid ? srcQ[0] : '0;
    outRdy  = rdy;
    #1;
    aAdd   = inValid && (inData != '0) && (mChan.size() < DEPTH);
    aBump  = inValid && (inData == '0);
    bValid = mChan.size() > 0;
    bHead  = bValid ? mChan[0] : '0;
    bAdd   = bValid && (bHead != '0) && rdy;
    bBump  = bValid && (bHead == '0);
    expSum = bHead + mIncB;
    if (aBump) tagIn = "R3";
    else if (aAdd) tagIn = "R2";
    else if (inValid) tagIn = "R4/R8 stall";
    else tagIn = "R5";
    if (bAdd) tagOut = (expSum < bHead) ? "R6" : "R7";
    else if (bBump) tagOut = "R3/R6";
    else if (bValid) tagOut = "R4";
    else tagOut = "R5";
    check(tagIn, W'(inDeq), W'(aAdd || aBump));
    check(tagOut, W'(outEnq), W'(bAdd));
    if (bAdd) check(tagOut, outData, expSum);
    if (bAdd || bBump) void'(mChan.pop_front());
    if (bBump) mIncB = mIncB + W'(1);
    if (bAdd) outLog.push_back(expSum);
    if (aAdd) mChan.push_back(inData + mIncA);
    if (aBump) mIncA = mIncA + W'(1);
    if (aAdd || aBump) void'(srcQ.pop_front());
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog (R7): actual hung run, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [W-1:0] golden [8];
    golden = '{32'd4, 32'd5, 32'd7, 32'd8, 32'd6, 32'd7, 32'd8, 32'd9};

    // R1: reset state, idle cycles
    doReset();
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);

    // R7: the reference ten-word sequence
    foreach (golden[i]) ;
    srcQ = '{1, 2, 0, 3, 4, 0, 1, 2, 3, 4};
    for (int i = 0; i < 30; i++) step(1'b1, 1'b1);
    check("R7 count", W'(outLog.size()), W'(8));
    for (int i = 0; i < 8; i++) check("R7 seq", (i < outLog.size()) ? outLog[i] : '0, golden[i]);

    // R3/R4/R8: sink blocked, channel fills, zero still consumed
    outLog.delete();
    srcQ = '{5, 6, 7, 8, 0, 9, 10};
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0);
    check("R8 stall left", W'(srcQ.size()), W'(2));
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1);

    // R6/R3: first-stage sum wraps to zero and bumps stage two while blocked
    srcQ.push_back('0 - mIncA);
    srcQ.push_back(W'(11));
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
    check("R6 stage-two bump", W'(mChan.size()), W'(1));
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1);
    srcQ.push_back(32'hFFFF_FFF0);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1);

    // Mixed pseudo-random traffic
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (srcQ.size() < 3) begin
        case (lfsr[3:2])
          2'd0:    srcQ.push_back('0);
          2'd1:    srcQ.push_back({16'hFFFF, lfsr});
          default: srcQ.push_back(W'(lfsr[7:0]));
        endcase
      end
      step(lfsr[5] | lfsr[6], lfsr[8] | lfsr[9]);
    end

    // R9: reset in the middle of traffic restores offsets
    doReset();
    step(1'b1, 1'b1);
    srcQ = '{5};
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1);
    check("R9 restored sum", (outLog.size() > 0) ? outLog[0] : '0, W'(5 + INC_A + INC_B));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule